// File: doc/BRIEF.md
# Snooped Bus Read Capture Buffer

This block watches the address and data lines of a slow CPU bus from a fast local clock. It stores the byte that a peripheral returns during a read the cartridge has scheduled. A sequencer arms the block with the address that the next read will target. The block then waits for the bus address to reach that value and move away again. The byte is taken at that departure and not while the address only matches, because the address settles hundreds of nanoseconds before the data is valid. Each arm yields at most one capture.

Captured bytes go into a sixteen-entry circular store. A host drains it by popping the oldest entry, or empties it with a clear strobe. When the host falls behind, a new capture replaces the oldest unread byte and raises a sticky overflow flag. The host sees the oldest byte, the fill count and an empty flag at all times.

Top module: `snoop_capture`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `count`=0) and `ovf` is 0.
- R2: An address departure is never captured unless the block was armed for that address by an `arm_stb` pulse.
- R3: While the bus address merely stays at the armed target, however long, nothing is stored. Only its departure stores a byte.
- R4: The stored byte is the data value sampled in the last cycle where the address still equalled the target. The value that arrives together with the new address is not stored.
- R5: An arm is consumed by its capture. A later visit to the same address without a new `arm_stb` stores nothing.
- R6: `rd_byte` shows the oldest stored byte, and a `host_pop` removes it (first in, first out). A `host_pop` while empty changes nothing.
- R7: With 16 entries held, a capture without a pop overwrites the oldest entry. `count` stays 16, `rd_byte` moves to the next oldest byte and `ovf` sets. `ovf` then stays set through pops.
- R8: `host_clear` sets `count` to 0, `empty` to 1 and `ovf` to 0. A capture in the same cycle is discarded.
- R9: A capture and a pop in the same cycle leave `count` unchanged. When the buffer is full this does not set `ovf`, and `rd_byte` advances by one entry.
- R10: Inputs pass through two synchronizing stages. The capture shows on `count` after the third rising edge that samples the departed address, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | CPU address bus, asynchronous to clk |
| bus_data | input | 8 | CPU data bus, asynchronous to clk |
| arm_stb | input | 1 | One-cycle pulse: arm a capture for `arm_addr` |
| arm_addr | input | 13 | Address of the scheduled read |
| host_pop | input | 1 | Remove the oldest stored byte |
| host_clear | input | 1 | Empty the buffer and clear `ovf` |
| rd_byte | output | 8 | Oldest stored byte |
| count | output | 5 | Number of stored bytes, 0 to 16 |
| empty | output | 1 | High when `count` is 0 |
| ovf | output | 1 | Sticky: a capture overwrote an unread byte |

## Verification
A capture write and a host pop can fall on the same clock edge. The bench provokes this by pulsing `host_pop` exactly on the third edge after an address departure, first with one entry held and then with sixteen. In the first case `count` must stay at 1 and `rd_byte` must become the new byte. In the full case `count` must stay at 16, `ovf` must stay low and `rd_byte` must show the former second-oldest byte. A capture that meets `host_clear` on the same edge is judged the same way and must leave the buffer empty.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  // Next fill level of the ring. A push into a full ring with no pop
  // replaces the oldest entry, so the level holds.
  function automatic int unsigned ring_level_next(input int unsigned lvl,
                                                  input logic push,
                                                  input logic take,
                                                  input int unsigned depth);
    if (push && !take && lvl == depth) return lvl;
    return lvl + (push ? 1 : 0) - (take ? 1 : 0);
  endfunction

  // Pointer increment with wrap for a power-of-two ring.
  function automatic int unsigned ring_ptr_next(input int unsigned p,
                                                input int unsigned depth);
    return (p + 1) % depth;
  endfunction

endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/snoop_trigger.sv
module snoop_trigger #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_now,
  input  logic [DATA_W-1:0] data_now,
  input  logic              arm_stb,
  input  logic [ADDR_W-1:0] arm_addr,
  output logic              cap_evt,
  output logic [DATA_W-1:0] cap_byte,
  output logic              armed
);
  logic [ADDR_W-1:0] addr_prev;
  logic [DATA_W-1:0] data_prev;
  logic [ADDR_W-1:0] target;
  logic              prev_ok;
  logic              prev_hit;
  logic              now_hit;

  assign prev_hit = prev_ok && (addr_prev == target);
  assign now_hit  = (addr_now == target);
  // Departure edge: last sample matched, this one does not.
  assign cap_evt  = armed && prev_hit && !now_hit;
  // Byte held on the last matching sample, before data may go stale.
  assign cap_byte = data_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_prev <= '0;
      data_prev <= '0;
      prev_ok   <= 1'b0;
      target    <= '0;
      armed     <= 1'b0;
    end else begin
      addr_prev <= addr_now;
      data_prev <= data_now;
      prev_ok   <= 1'b1;
      if (arm_stb) begin
        target <= arm_addr;
        armed  <= 1'b1;
      end else if (cap_evt) begin
        armed  <= 1'b0;
      end
    end
  end

  // R5: a capture consumes the arm unless a new arm arrives with it
  p_disarm_after_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !arm_stb) |=> !armed);

  // R2: an arm pulse always leaves the block armed
  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_stb |=> armed);

  // R3: no capture while the address holds still
  p_no_cap_on_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && addr_now == addr_prev) |-> !cap_evt);
endmodule

// File: rtl/snoop_ring.sv
module snoop_ring
  import snoop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              host_pop,
  input  logic              host_clear,
  output logic [DATA_W-1:0] rd_byte,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              empty,
  output logic              ovf
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              pop_ok;
  logic              full;
  logic              wrap_drop;

  assign full      = (int'(count) == DEPTH);
  assign empty     = (count == '0);
  assign pop_ok    = host_pop && !empty;
  assign wrap_drop = wr && !pop_ok && full;
  assign rd_byte   = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n || host_clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end
    end else begin
      if (wr) begin
        mem[wptr] <= wr_byte;
        wptr      <= PTR_W'(ring_ptr_next(int'(wptr), DEPTH));
      end
      if (pop_ok || wrap_drop)
        rptr <= PTR_W'(ring_ptr_next(int'(rptr), DEPTH));
      count <= CNT_W'(ring_level_next(int'(count), wr, pop_ok, DEPTH));
      if (wrap_drop) ovf <= 1'b1;
    end
  end

  // R7: level never exceeds the depth
  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R7: overwrite on a full ring keeps it full and flags it
  p_wrap_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !host_pop && full && !host_clear) |=> (full && ovf));

  // R7: overflow is sticky until a clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !host_clear) |=> ovf);

  // R8: clear empties and drops the flag
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |=> (empty && !ovf));

  // R6: pop on empty has no effect
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && empty && !wr) |=> empty);

  // R9: simultaneous write and pop keep the level
  p_write_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && host_pop && !empty && !host_clear) |=> $stable(count));
endmodule

// File: rtl/snoop_capture.sv
module snoop_capture #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              arm_stb,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              host_pop,
  input  logic              host_clear,
  output logic [DATA_W-1:0] rd_byte,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              empty,
  output logic              ovf
);
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              cap_evt;
  logic [DATA_W-1:0] cap_byte;
  logic              armed;

  snoop_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(bus_addr), .q(addr_s));

  snoop_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(bus_data), .q(data_s));

  snoop_trigger #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trig (
    .clk(clk), .rst_n(rst_n),
    .addr_now(addr_s), .data_now(data_s),
    .arm_stb(arm_stb), .arm_addr(arm_addr),
    .cap_evt(cap_evt), .cap_byte(cap_byte), .armed(armed));

  snoop_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr(cap_evt), .wr_byte(cap_byte),
    .host_pop(host_pop), .host_clear(host_clear),
    .rd_byte(rd_byte), .count(count), .empty(empty), .ovf(ovf));

  // R2: a capture only ever happens while armed
  p_cap_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !$past(arm_stb)) |-> !cap_evt);
endmodule

// File: tb/snoop_capture_test.sv
module snoop_capture_test;
  localparam logic [12:0] IDLE = 13'h1F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = IDLE;
  logic [7:0]  bus_data = 8'h00;
  logic        arm_stb = 1'b0;
  logic [12:0] arm_addr = '0;
  logic        host_pop = 1'b0;
  logic        host_clear = 1'b0;
  logic [7:0]  rd_byte;
  logic [4:0]  count;
  logic        empty;
  logic        ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  snoop_capture uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .arm_stb(arm_stb), .arm_addr(arm_addr), .host_pop(host_pop),
    .host_clear(host_clear), .rd_byte(rd_byte), .count(count),
    .empty(empty), .ovf(ovf));

  // {arm, address, data}
  localparam logic [21:0] VEC [8] = '{
    {1'b1, 13'h0280, 8'h5A},
    {1'b0, 13'h0281, 8'h11},
    {1'b1, 13'h0282, 8'hC3},
    {1'b1, 13'h0280, 8'h00},
    {1'b0, 13'h0280, 8'h77},
    {1'b1, 13'h0001, 8'hFF},
    {1'b1, 13'h0283, 8'hA5},
    {1'b0, 13'h0283, 8'h3C}
  };

  logic [7:0] mdl [32];
  int mhead = 0;
  int mtail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [12:0] a);
    @(negedge clk);
    arm_stb = 1'b1;
    arm_addr = a;
    @(negedge clk);
    arm_stb = 1'b0;
  endtask

  // Park on a, then leave with stale data; pulse pop/clear on the third edge.
  task automatic visit(input logic [12:0] a, input logic [7:0] d,
                       input logic pop, input logic clr);
    @(negedge clk);
    bus_addr = a;
    bus_data = d;
    repeat (4) @(negedge clk);
    bus_addr = IDLE;
    bus_data = ~d;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    host_pop = pop;
    host_clear = clr;
    @(posedge clk);
    @(negedge clk);
    host_pop = 1'b0;
    host_clear = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop_one;
    @(negedge clk);
    host_pop = 1'b1;
    @(negedge clk);
    host_pop = 1'b0;
  endtask

  task automatic clear_all;
    @(negedge clk);
    host_clear = 1'b1;
    @(negedge clk);
    host_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty after reset", int'(empty), 1);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 ovf after reset", int'(ovf), 0);

    // Table walk: R2, R4, R5
    for (int i = 0; i < 8; i++) begin
      logic        a_on;
      logic [12:0] a;
      logic [7:0]  d;
      {a_on, a, d} = VEC[i];
      if (a_on) arm(a);
      visit(a, d, 1'b0, 1'b0);
      if (a_on) begin
        mdl[mtail] = d;
        mtail++;
      end
      chk($sformatf("R2 R4 R5 table count step %0d", i), int'(count), mtail - mhead);
      chk($sformatf("R4 table head step %0d", i), int'(rd_byte), int'(mdl[mhead]));
    end
    while (mhead < mtail) begin
      chk("R6 fifo order", int'(rd_byte), int'(mdl[mhead]));
      pop_one();
      mhead++;
    end
    chk("R6 drained", int'(empty), 1);
    pop_one();
    chk("R6 pop on empty keeps count", int'(count), 0);
    chk("R6 pop on empty keeps ovf", int'(ovf), 0);

    // R3: long hold at the target stores nothing
    arm(13'h0280);
    @(negedge clk);
    bus_addr = 13'h0280;
    bus_data = 8'h42;
    repeat (30) @(negedge clk);
    chk("R3 no capture while matching", int'(count), 0);
    bus_addr = IDLE;
    bus_data = 8'hBD;
    // R10: count moves on the third edge, not the second
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R10 not yet after two edges", int'(count), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 stored after third edge", int'(count), 1);
    chk("R4 byte before departure", int'(rd_byte), 8'h42);

    // R5: revisit without re-arming
    visit(13'h0280, 8'h99, 1'b0, 1'b0);
    chk("R5 no second capture", int'(count), 1);

    // R9: write and pop in one cycle with one entry held
    arm(13'h0284);
    visit(13'h0284, 8'h6E, 1'b1, 1'b0);
    chk("R9 count held", int'(count), 1);
    chk("R9 new head", int'(rd_byte), 8'h6E);

    // R8: clear and empty
    clear_all();
    chk("R8 cleared count", int'(count), 0);
    chk("R8 cleared empty", int'(empty), 1);

    // Fill to 16
    for (int i = 0; i < 16; i++) begin
      arm(13'h0290);
      visit(13'h0290, 8'(8'h10 + i), 1'b0, 1'b0);
    end
    chk("R7 full count", int'(count), 16);
    chk("R7 no ovf at exactly full", int'(ovf), 0);

    // R9 full: write plus pop, no overflow
    arm(13'h0290);
    visit(13'h0290, 8'hE1, 1'b1, 1'b0);
    chk("R9 full count held", int'(count), 16);
    chk("R9 full no ovf", int'(ovf), 0);
    chk("R9 full head advanced", int'(rd_byte), 8'h11);

    // R7: overwrite oldest
    arm(13'h0290);
    visit(13'h0290, 8'hEE, 1'b0, 1'b0);
    chk("R7 count stays 16", int'(count), 16);
    chk("R7 ovf set", int'(ovf), 1);
    chk("R7 oldest dropped", int'(rd_byte), 8'h12);
    pop_one();
    chk("R7 ovf sticky after pop", int'(ovf), 1);
    chk("R7 count after pop", int'(count), 15);
    chk("R7 next head", int'(rd_byte), 8'h13);

    // R8: clear wins over a simultaneous capture
    arm(13'h0291);
    visit(13'h0291, 8'h55, 1'b0, 1'b1);
    chk("R8 clear beats capture count", int'(count), 0);
    chk("R8 clear drops ovf", int'(ovf), 0);
    chk("R8 empty", int'(empty), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule